// File: doc/BRIEF.md
# Recency-Linked TLB with Neighbour Preloading

This block is a small fully associative translation buffer. Its replacement order doubles as a recency stack, running from the most recently used page to the least recently used one. A lookup port takes a virtual page number. A page that is resident answers with its physical frame one cycle later. A page that is not resident is fetched through a simple walker request/response pair, and the fetched entry is installed as the youngest entry.

Every entry pushed out of the oldest slot is recorded in a page-side link store, together with its frame. The record holds a link to the page evicted just before it (its older neighbour). The record of that earlier page gains a link to the newly evicted page (its younger neighbour). After a miss has been filled, the block looks at the two neighbours recorded for the missed page and offers each one as a preload, younger neighbour first. An accepted preload is installed one slot below the youngest, so the demand fill stays on top.

All data moves through valid/ready pairs, with one exception: the lookup response is a one-cycle pulse with no ready. The lookup port deasserts `req_ready` from the acceptance of a miss until its preload phase ends. The walker request holds its page number while `walk_req_ready` is low. The walker response is taken only while `walk_rsp_ready` is high. A preload offer keeps its valid, page and frame while `pl_ready` is low.

Top module: `recency_tlb`

## Requirements
- R1: After reset the buffer and every link record are empty. `req_ready` is high, and `resp_valid`, `walk_req_valid`, `walk_rsp_ready` and `pl_valid` are low. The first lookup of any page misses.
- R2: A lookup accepted while the page is resident gives `resp_valid=1`, `resp_hit=1` and the stored frame in the next cycle. The entry becomes the youngest.
- R3: When all ENTRIES slots are valid, any insertion removes the least recently used entry. Both hits and installs count as uses.
- R4: A lookup accepted for a page that is not resident raises `walk_req_valid` in the next cycle, carrying that page. The request is held until `walk_req_ready`. From the cycle after that handshake, `walk_rsp_ready` stays high until `walk_rsp_valid` arrives.
- R5: The walker response handshake installs the page as the youngest entry. In the next cycle it gives `resp_valid=1` and `resp_hit=0`, with the frame returned by the walker.
- R6: An entry evicted from the oldest slot is recorded with its frame. Its younger link is cleared. If an earlier eviction of a different page exists, the new record links older to that page, and that page's record links younger to the new one.
- R7: The links read are those of the missed page at the moment the miss is accepted. The preload slot for the younger link comes in the cycle after the fill handshake. The slot for the older link follows it. Each offer carries the linked page and its recorded frame.
- R8: A preload slot whose link is absent, or whose page is resident at that moment, raises no `pl_valid` and passes after one cycle.
- R9: While `pl_valid=1` and `pl_ready=0`, `pl_valid`, `pl_vpn` and `pl_pfn` stay unchanged.
- R10: An accepted preload is installed as the second-youngest entry. It evicts the oldest entry if the buffer is full.
- R11: Only one miss is handled at a time. `req_ready` is high only when no miss or preload slot is pending, and at most one of `req_ready`, `walk_req_valid`, `walk_rsp_ready` and `pl_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_vpn | input | VPN_W | Virtual page to translate |
| resp_valid | output | 1 | One-cycle lookup result pulse |
| resp_hit | output | 1 | Result came from a resident entry |
| resp_pfn | output | PFN_W | Physical frame of the result |
| walk_req_valid | output | 1 | Walker request valid |
| walk_req_ready | input | 1 | Walker takes the request |
| walk_req_vpn | output | VPN_W | Page the walker must resolve |
| walk_rsp_valid | input | 1 | Walker response valid |
| walk_rsp_ready | output | 1 | Block is waiting for the walker response |
| walk_rsp_pfn | input | PFN_W | Frame returned by the walker |
| pl_valid | output | 1 | Preload offer valid |
| pl_ready | input | 1 | Preload offer accepted |
| pl_vpn | output | VPN_W | Preloaded page |
| pl_pfn | output | PFN_W | Frame of the preloaded page |

## Verification
A hit result is due exactly one cycle after the lookup handshake. A miss result is due one cycle after the walker response handshake. The walker request is due one cycle after the miss is taken, and the first preload slot falls in the same cycle as the miss result. The bench keeps a behavioural model that applies each handshake at the clock edge where it occurs. The model sets what every output must show in the following cycle, and all outputs are compared against it in the middle of every cycle. As a result, a result or offer that comes a cycle early or late, or that names the wrong page, is reported where it occurs. Random stalls on the walker and preload ports exercise the hold rules.

// File: rtl/recency_tlb_pkg.sv
package recency_tlb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WALK,
    PH_WAIT,
    PH_PRE_YNG,
    PH_PRE_OLD
  } rtlb_phase_e;
endpackage

// File: rtl/rtlb_lru_stack.sv
// Ordered entry array: slot 0 is youngest, slot ENTRIES-1 oldest.
// Valid slots are always contiguous from slot 0.
module rtlb_lru_stack #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 6,
  parameter int PFN_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             look_hit,
  output logic [IDX_W-1:0] look_idx,
  output logic [PFN_W-1:0] look_pfn,
  input  logic [VPN_W-1:0] probe_vpn,
  output logic             probe_hit,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             ins_en,
  input  logic             ins_second,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PFN_W-1:0] ins_pfn,
  output logic             full,
  output logic [VPN_W-1:0] old_vpn,
  output logic [PFN_W-1:0] old_pfn
);
  logic             v_q   [ENTRIES];
  logic [VPN_W-1:0] vpn_q [ENTRIES];
  logic [PFN_W-1:0] pfn_q [ENTRIES];
  logic             v_d   [ENTRIES];
  logic [VPN_W-1:0] vpn_d [ENTRIES];
  logic [PFN_W-1:0] pfn_d [ENTRIES];
  logic [ENTRIES-1:0] hit_vec, probe_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g]   = v_q[g] && (vpn_q[g] == look_vpn);
    assign probe_vec[g] = v_q[g] && (vpn_q[g] == probe_vpn);
  end

  assign look_hit  = |hit_vec;
  assign probe_hit = |probe_vec;
  assign full      = v_q[ENTRIES-1];
  assign old_vpn   = vpn_q[ENTRIES-1];
  assign old_pfn   = pfn_q[ENTRIES-1];

  always_comb begin
    look_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) look_idx = IDX_W'(i);
  end
  assign look_pfn = pfn_q[look_idx];

  always_comb begin
    int pos;
    int tix;
    pos = ins_second ? 1 : 0;
    tix = int'(touch_idx);
    v_d = v_q;
    vpn_d = vpn_q;
    pfn_d = pfn_q;
    if (ins_en) begin
      for (int i = 1; i < ENTRIES; i++)
        if (i > pos) begin
          v_d[i]   = v_q[i-1];
          vpn_d[i] = vpn_q[i-1];
          pfn_d[i] = pfn_q[i-1];
        end
      v_d[pos]   = 1'b1;
      vpn_d[pos] = ins_vpn;
      pfn_d[pos] = ins_pfn;
    end else if (touch_en) begin
      for (int i = 1; i < ENTRIES; i++)
        if (i <= tix) begin
          v_d[i]   = v_q[i-1];
          vpn_d[i] = vpn_q[i-1];
          pfn_d[i] = pfn_q[i-1];
        end
      v_d[0]   = v_q[tix];
      vpn_d[0] = vpn_q[tix];
      pfn_d[0] = pfn_q[tix];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) v_q[i] <= 1'b0;
    end else begin
      v_q <= v_d;
    end
    vpn_q <= vpn_d;
    pfn_q <= pfn_d;
  end
endmodule

// File: rtl/rtlb_link_store.sv
// Page-indexed record of evicted translations and their recency links.
module rtlb_link_store #(
  parameter int VPN_W  = 6,
  parameter int PFN_W  = 8,
  localparam int DEPTH = 1 << VPN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evict_en,
  input  logic [VPN_W-1:0] evict_vpn,
  input  logic [PFN_W-1:0] evict_pfn,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic             rd_yng_v,
  output logic [VPN_W-1:0] rd_yng,
  output logic             rd_old_v,
  output logic [VPN_W-1:0] rd_old,
  input  logic [VPN_W-1:0] tg_vpn,
  output logic [PFN_W-1:0] tg_pfn
);
  logic [PFN_W-1:0] frame_m [DEPTH];
  logic             yng_v_m [DEPTH];
  logic [VPN_W-1:0] yng_m   [DEPTH];
  logic             old_v_m [DEPTH];
  logic [VPN_W-1:0] old_m   [DEPTH];
  logic             last_v;
  logic [VPN_W-1:0] last_q;
  logic             chain;

  assign rd_yng_v = yng_v_m[rd_vpn];
  assign rd_yng   = yng_m[rd_vpn];
  assign rd_old_v = old_v_m[rd_vpn];
  assign rd_old   = old_m[rd_vpn];
  assign tg_pfn   = frame_m[tg_vpn];
  assign chain    = last_v && (last_q != evict_vpn);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        yng_v_m[i] <= 1'b0;
        old_v_m[i] <= 1'b0;
      end
      last_v <= 1'b0;
      last_q <= '0;
    end else if (evict_en) begin
      frame_m[evict_vpn] <= evict_pfn;
      yng_v_m[evict_vpn] <= 1'b0;
      old_v_m[evict_vpn] <= chain;
      old_m[evict_vpn]   <= last_q;
      if (chain) begin
        yng_v_m[last_q] <= 1'b1;
        yng_m[last_q]   <= evict_vpn;
      end
      last_v <= 1'b1;
      last_q <= evict_vpn;
    end
  end
endmodule

// File: rtl/recency_tlb.sv
module recency_tlb
  import recency_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 6,
  parameter int PFN_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [PFN_W-1:0] resp_pfn,
  output logic             walk_req_valid,
  input  logic             walk_req_ready,
  output logic [VPN_W-1:0] walk_req_vpn,
  input  logic             walk_rsp_valid,
  output logic             walk_rsp_ready,
  input  logic [PFN_W-1:0] walk_rsp_pfn,
  output logic             pl_valid,
  input  logic             pl_ready,
  output logic [VPN_W-1:0] pl_vpn,
  output logic [PFN_W-1:0] pl_pfn
);
  rtlb_phase_e      phase_q, phase_d;
  logic [VPN_W-1:0] miss_q;
  logic             snap_yng_v, snap_old_v;
  logic [VPN_W-1:0] snap_yng, snap_old;

  logic             look_hit, probe_hit, full;
  logic [IDX_W-1:0] look_idx;
  logic [PFN_W-1:0] look_pfn, old_pfn, tg_pfn;
  logic [VPN_W-1:0] old_vpn;
  logic             rd_yng_v, rd_old_v;
  logic [VPN_W-1:0] rd_yng, rd_old;

  logic             accept, fill, in_pre, pre_link_v, pre_take, ins_en;
  logic [VPN_W-1:0] pre_vpn;

  assign req_ready      = (phase_q == PH_IDLE);
  assign accept         = req_valid && req_ready;
  assign walk_req_valid = (phase_q == PH_WALK);
  assign walk_req_vpn   = miss_q;
  assign walk_rsp_ready = (phase_q == PH_WAIT);
  assign fill           = walk_rsp_ready && walk_rsp_valid;

  assign in_pre     = (phase_q == PH_PRE_YNG) || (phase_q == PH_PRE_OLD);
  assign pre_link_v = (phase_q == PH_PRE_YNG) ? snap_yng_v : snap_old_v;
  assign pre_vpn    = (phase_q == PH_PRE_YNG) ? snap_yng : snap_old;
  assign pl_valid   = in_pre && pre_link_v && !probe_hit;
  assign pl_vpn     = pre_vpn;
  assign pl_pfn     = tg_pfn;
  assign pre_take   = pl_valid && pl_ready;
  assign ins_en     = fill || pre_take;

  rtlb_lru_stack #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_vpn   (req_vpn),
    .look_hit   (look_hit),
    .look_idx   (look_idx),
    .look_pfn   (look_pfn),
    .probe_vpn  (pre_vpn),
    .probe_hit  (probe_hit),
    .touch_en   (accept && look_hit),
    .touch_idx  (look_idx),
    .ins_en     (ins_en),
    .ins_second (!fill),
    .ins_vpn    (fill ? miss_q : pre_vpn),
    .ins_pfn    (fill ? walk_rsp_pfn : tg_pfn),
    .full       (full),
    .old_vpn    (old_vpn),
    .old_pfn    (old_pfn)
  );

  rtlb_link_store #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_links (
    .clk       (clk),
    .rst_n     (rst_n),
    .evict_en  (ins_en && full),
    .evict_vpn (old_vpn),
    .evict_pfn (old_pfn),
    .rd_vpn    (req_vpn),
    .rd_yng_v  (rd_yng_v),
    .rd_yng    (rd_yng),
    .rd_old_v  (rd_old_v),
    .rd_old    (rd_old),
    .tg_vpn    (pre_vpn),
    .tg_pfn    (tg_pfn)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:    if (accept && !look_hit) phase_d = PH_WALK;
      PH_WALK:    if (walk_req_ready)      phase_d = PH_WAIT;
      PH_WAIT:    if (walk_rsp_valid)      phase_d = PH_PRE_YNG;
      PH_PRE_YNG: if (!pl_valid || pl_ready) phase_d = PH_PRE_OLD;
      PH_PRE_OLD: if (!pl_valid || pl_ready) phase_d = PH_IDLE;
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_pfn   <= '0;
      miss_q     <= '0;
      snap_yng_v <= 1'b0;
      snap_old_v <= 1'b0;
      snap_yng   <= '0;
      snap_old   <= '0;
    end else begin
      phase_q    <= phase_d;
      resp_valid <= (accept && look_hit) || fill;
      resp_hit   <= accept && look_hit;
      resp_pfn   <= fill ? walk_rsp_pfn : look_pfn;
      if (accept && !look_hit) begin
        miss_q     <= req_vpn;
        snap_yng_v <= rd_yng_v;
        snap_yng   <= rd_yng;
        snap_old_v <= rd_old_v;
        snap_old   <= rd_old;
      end
    end
  end
endmodule

// File: rtl/recency_tlb_chk.sv
module recency_tlb_chk #(
  parameter int VPN_W = 6,
  parameter int PFN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic [PFN_W-1:0] resp_pfn,
  input logic             walk_req_valid,
  input logic             walk_req_ready,
  input logic [VPN_W-1:0] walk_req_vpn,
  input logic             walk_rsp_valid,
  input logic             walk_rsp_ready,
  input logic [PFN_W-1:0] walk_rsp_pfn,
  input logic             pl_valid,
  input logic             pl_ready,
  input logic [VPN_W-1:0] pl_vpn,
  input logic [PFN_W-1:0] pl_pfn
);
  p_walk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid && !walk_req_ready |=> walk_req_valid && $stable(walk_req_vpn));

  p_fill_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    walk_rsp_valid && walk_rsp_ready |=> resp_valid && !resp_hit && resp_pfn == $past(walk_rsp_pfn));

  p_resp_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && req_ready) || $past(walk_rsp_valid && walk_rsp_ready));

  p_pl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid && !pl_ready |=> pl_valid && $stable(pl_vpn) && $stable(pl_pfn));

  p_one_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, walk_req_valid, walk_rsp_ready, pl_valid}));

  p_pl_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    walk_rsp_valid && walk_rsp_ready |=> !req_ready && !walk_req_valid);
endmodule

bind recency_tlb recency_tlb_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_pfn(resp_pfn),
  .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready),
  .walk_req_vpn(walk_req_vpn), .walk_rsp_valid(walk_rsp_valid),
  .walk_rsp_ready(walk_rsp_ready), .walk_rsp_pfn(walk_rsp_pfn),
  .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_vpn(pl_vpn), .pl_pfn(pl_pfn)
);

// File: tb/recency_tlb_tb.sv
module recency_tlb_tb;
  localparam int ENTRIES = 8;
  localparam int VPN_W   = 6;
  localparam int PFN_W   = 8;
  localparam int PAGES   = 1 << VPN_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [VPN_W-1:0] req_vpn = '0;
  logic             resp_valid, resp_hit;
  logic [PFN_W-1:0] resp_pfn;
  logic             walk_req_valid;
  logic             walk_req_ready = 1'b0;
  logic [VPN_W-1:0] walk_req_vpn;
  logic             walk_rsp_valid = 1'b0;
  logic             walk_rsp_ready;
  logic [PFN_W-1:0] walk_rsp_pfn = '0;
  logic             pl_valid;
  logic             pl_ready = 1'b0;
  logic [VPN_W-1:0] pl_vpn;
  logic [PFN_W-1:0] pl_pfn;

  always #2 clk = ~clk;

  recency_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_pfn(resp_pfn), .walk_req_valid(walk_req_valid),
    .walk_req_ready(walk_req_ready), .walk_req_vpn(walk_req_vpn),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ready(walk_rsp_ready),
    .walk_rsp_pfn(walk_rsp_pfn), .pl_valid(pl_valid), .pl_ready(pl_ready),
    .pl_vpn(pl_vpn), .pl_pfn(pl_pfn)
  );

  int compared = 0;
  int mismatched = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int frame_of(input int v);
    return (v * 37 + 11) % (1 << PFN_W);
  endfunction

  int unsigned seed = 32'h1234_5678;
  function automatic int rnd(input int m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % m);
  endfunction

  // Behavioural model: page list youngest first, link records by page.
  int q[$];
  int myng[PAGES];
  int mold[PAGES];
  int mlast = -1;
  int mph = 0;          // 0 idle, 1 walk, 2 wait, 3 younger slot, 4 older slot
  int mmiss = 0;
  int t_yng = -1, t_old = -1;
  bit nr_v = 0, nr_hit = 0;
  int nr_pfn = 0;
  bit stalled = 0;

  function automatic int find(input int v);
    foreach (q[i]) if (q[i] == v) return i;
    return -1;
  endfunction

  task automatic m_insert(input int v, input int pos);
    if (q.size() == ENTRIES) begin
      int e;
      e = q.pop_back();
      myng[e] = -1;
      if (mlast >= 0 && mlast != e) begin
        mold[e] = mlast;
        myng[mlast] = e;
      end else begin
        mold[e] = -1;
      end
      mlast = e;
    end
    q.insert(pos, v);
  endtask

  int script[$];
  int sidx = 0;
  bit req_taken = 0, rsp_taken = 0;
  bit wpend = 0;
  int wdelay = 0, wvpn = 0;
  int idle_run = 0;
  int cyc = 0;

  initial begin
    for (int i = 0; i < PAGES; i++) begin
      myng[i] = -1;
      mold[i] = -1;
    end
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 16; i++) script.push_back(i);
    script.push_back(15); script.push_back(14); script.push_back(13);
    script.push_back(15); script.push_back(2); script.push_back(2);
    script.push_back(9);  script.push_back(5);
    for (int i = 0; i < 600; i++) script.push_back(rnd(20));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "req_ready in reset", int'(req_ready), 1);
    chk("R1", "resp_valid in reset", int'(resp_valid), 0);
    chk("R1", "walk_req_valid in reset", int'(walk_req_valid), 0);
    chk("R1", "walk_rsp_ready in reset", int'(walk_rsp_ready), 0);
    chk("R1", "pl_valid in reset", int'(pl_valid), 0);
    rst_n = 1'b1;

    while (1) begin
      int t;
      bit epv;
      string ptag;
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        mismatched++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        break;
      end
      if (req_taken) begin req_valid = 1'b0; req_taken = 0; end
      if (rsp_taken) begin walk_rsp_valid = 1'b0; rsp_taken = 0; wpend = 0; end

      // expectations for this cycle
      t = (mph == 3) ? t_yng : t_old;
      epv = (mph >= 3) && (t >= 0) && (find(t) < 0);
      chk("R11", "req_ready", int'(req_ready), int'(mph == 0));
      chk("R2 R3 R5 R10", "resp_valid", int'(resp_valid), int'(nr_v));
      if (nr_v) begin
        chk("R2 R3 R10", "resp_hit", int'(resp_hit), int'(nr_hit));
        chk("R2 R5", "resp_pfn", int'(resp_pfn), nr_pfn);
      end
      chk("R4", "walk_req_valid", int'(walk_req_valid), int'(mph == 1));
      if (mph == 1) chk("R4", "walk_req_vpn", int'(walk_req_vpn), mmiss);
      chk("R4", "walk_rsp_ready", int'(walk_rsp_ready), int'(mph == 2));
      ptag = stalled ? "R9" : "R6 R7 R8";
      chk(ptag, "pl_valid", int'(pl_valid), int'(epv));
      if (epv) begin
        chk(ptag, "pl_vpn", int'(pl_vpn), t);
        chk("R6 R7", "pl_pfn", int'(pl_pfn), frame_of(t));
      end

      // drive inputs for the coming edge
      if (!req_valid && sidx < script.size() && rnd(8) != 0) begin
        req_valid = 1'b1;
        req_vpn = VPN_W'(script[sidx]);
        sidx++;
      end
      walk_req_ready = (rnd(10) < 7);
      pl_ready = (rnd(10) < 6);
      if (wpend && !walk_rsp_valid) begin
        if (wdelay == 0) begin
          walk_rsp_valid = 1'b1;
          walk_rsp_pfn = PFN_W'(frame_of(wvpn));
        end else wdelay--;
      end

      // model: apply handshakes of the coming edge
      nr_v = 0;
      stalled = 0;
      case (mph)
        0: if (req_valid) begin
             int k;
             req_taken = 1;
             k = find(int'(req_vpn));
             if (k >= 0) begin
               q.delete(k);
               q.push_front(int'(req_vpn));
               nr_v = 1; nr_hit = 1; nr_pfn = frame_of(int'(req_vpn));
             end else begin
               mmiss = int'(req_vpn);
               t_yng = myng[mmiss];
               t_old = mold[mmiss];
               mph = 1;
             end
           end
        1: if (walk_req_ready) begin
             wpend = 1; wvpn = int'(walk_req_vpn); wdelay = rnd(4);
             mph = 2;
           end
        2: if (walk_rsp_valid) begin
             rsp_taken = 1;
             m_insert(mmiss, 0);
             nr_v = 1; nr_hit = 0; nr_pfn = int'(walk_rsp_pfn);
             mph = 3;
           end
        default: begin
             if (epv && pl_ready) m_insert(t, 1);
             if (!epv || pl_ready) mph = (mph == 3) ? 4 : 0;
             else stalled = 1;
           end
      endcase

      if (sidx >= script.size() && mph == 0 && !req_valid && !nr_v) idle_run++;
      else idle_run = 0;
      if (idle_run > 4) break;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule